// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Flag Register

This block performs one arithmetic or logical operation per clock on two operands. The operands are either 8 or 16 bits wide. The result and a 16-bit status word are both registered. The operations are add, add with carry-in, subtract, subtract with borrow-in, compare, AND, OR and XOR. Each operation selected by `op_valid` refreshes the condition flags from the new result. The condition flags are carry, parity, half carry, zero, sign and overflow. The control flags are direction, interrupt and single-step. They are held in the same word and are set or cleared by dedicated strobes on any clock, whether or not an operation is active.

Operation encoding on `op_sel`: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 AND, 6 OR, 7 XOR. When `word_mode` is 1 the operands are 16 bits. When it is 0 only the low 8 bits of each operand are used.

Top module: `alu_flag_unit`

## Requirements
- R1: Add (0) and add-with-carry (1) produce a+b (+ flag bit 0 for op 1), truncated to the operand width. Flag bit 0 (carry) is set on a carry out of the top operand bit.
- R2: Subtract (2) and subtract-with-borrow (3) produce a-b (- flag bit 0 for op 3). Flag bit 0 is set when a borrow into the top bit occurs.
- R3: Flag bit 11 (overflow) is set when the signed result of an arithmetic operation falls outside the signed range of the operand width.
- R4: Flag bit 4 (half carry) is set on a carry or borrow across bit 3, in both widths.
- R5: Flag bit 7 (sign) equals the top bit of the result at the operand width. Flag bit 6 (zero) is set when the result at the operand width is all zeros.
- R6: Flag bit 2 (parity) is 1 when bits 7..0 of the result contain an even number of ones, in both widths.
- R7: AND (5), OR (6) and XOR (7) write the bitwise result and clear flag bits 0, 4 and 11.
- R8: Compare (4) updates the condition flags exactly as subtract would. It leaves the result output unchanged.
- R9: In byte mode, bits 15..8 of the written result are zero and the flags come from the 8-bit operation.
- R10: Strobes set/clear flag bit 10 (direction), bit 9 (interrupt) and bit 8 (single-step) on the next clock, independently of `op_valid`. Clear wins when a flag's set and clear strobes are both high.
- R11: Flag bit 1 always reads 1, and bits 3, 5 and 15..12 always read 0.
- R12: With `op_valid` low, the result and flag bits 0, 2, 4, 6, 7 and 11 hold their values.
- R13: After reset, the result is 0 and the flag word is 16'h0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Perform the selected operation this cycle |
| op_sel | input | 3 | Operation code |
| word_mode | input | 1 | 1: 16-bit operands, 0: 8-bit operands |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| dir_set | input | 1 | Set direction flag |
| dir_clr | input | 1 | Clear direction flag |
| int_set | input | 1 | Set interrupt flag |
| int_clr | input | 1 | Clear interrupt flag |
| step_set | input | 1 | Set single-step flag |
| step_clr | input | 1 | Clear single-step flag |
| result | output | 16 | Registered result |
| flags | output | 16 | Registered flag word |

## Verification
The assertions need no handshake on the inputs. They do assume that every input is at a known level at each rising edge, including opcode values and the case where a set and a clear strobe are both high. The bench changes inputs only on falling edges and drives every input on every vector. It deliberately includes simultaneous set and clear strobes and idle cycles, so the priority and hold properties are actually exercised. Operand values are chosen at the signed and unsigned limits of both widths, where the carry, half-carry and overflow properties become decisive.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_CMP = 3'd4,
        OP_AND = 3'd5,
        OP_OR  = 3'd6,
        OP_XOR = 3'd7
    } alu_op_e;

    localparam int FLAG_W   = 16;
    localparam int FB_CARRY = 0;
    localparam int FB_ONE   = 1;
    localparam int FB_PAR   = 2;
    localparam int FB_HALF  = 4;
    localparam int FB_ZERO  = 6;
    localparam int FB_SIGN  = 7;
    localparam int FB_STEP  = 8;
    localparam int FB_INT   = 9;
    localparam int FB_DIR   = 10;
    localparam int FB_OVF   = 11;

    localparam int NUM_CTL = 3;

    localparam logic [FLAG_W-1:0] FLAGS_RESET = 16'h0002;

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic              word_mode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res,
    output logic              cf,
    output logic              af,
    output logic              of
);
    localparam int HALF_W = DATA_W / 2;

    logic              is_sub, is_logic, c0;
    logic [DATA_W-1:0] b_eff, lres, ares, xsum;
    logic [DATA_W:0]   wide;
    logic [HALF_W:0]   narrow;
    logic              a_msb, b_msb, r_msb, cout;

    always_comb begin
        is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
        is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
        c0       = (((op == OP_ADC) || (op == OP_SBB)) ? carry_in : 1'b0) ^ is_sub;
        b_eff    = is_sub ? ~b : b;

        wide   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c0};
        narrow = {1'b0, a[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]} + {{HALF_W{1'b0}}, c0};

        ares = word_mode ? wide[DATA_W-1:0] : {{HALF_W{1'b0}}, narrow[HALF_W-1:0]};
        cout = word_mode ? wide[DATA_W] : narrow[HALF_W];

        unique case (op)
            OP_AND:  lres = a & b;
            OP_OR:   lres = a | b;
            default: lres = a ^ b;
        endcase
        if (!word_mode) begin
            lres[DATA_W-1:HALF_W] = '0;
        end

        a_msb = word_mode ? a[DATA_W-1]     : a[HALF_W-1];
        b_msb = word_mode ? b_eff[DATA_W-1] : b_eff[HALF_W-1];
        r_msb = word_mode ? ares[DATA_W-1]  : ares[HALF_W-1];
        xsum  = a ^ b_eff ^ wide[DATA_W-1:0];

        res = is_logic ? lres : ares;
        cf  = is_logic ? 1'b0 : (cout ^ is_sub);
        af  = is_logic ? 1'b0 : (xsum[4] ^ is_sub);
        of  = is_logic ? 1'b0 : ((a_msb == b_msb) && (r_msb != a_msb));
    end

endmodule

// File: rtl/alu_status.sv
module alu_status #(
    parameter int DATA_W = 16
) (
    input  logic              word_mode,
    input  logic [DATA_W-1:0] res,
    output logic              sf,
    output logic              zf,
    output logic              pf
);
    localparam int HALF_W = DATA_W / 2;
    localparam int PAR_W  = 8;

    always_comb begin
        sf = word_mode ? res[DATA_W-1] : res[HALF_W-1];
        zf = word_mode ? (res == '0) : (res[HALF_W-1:0] == '0);
        pf = ~^res[PAR_W-1:0];
    end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_sel,
    input  logic              word_mode,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              dir_set,
    input  logic              dir_clr,
    input  logic              int_set,
    input  logic              int_clr,
    input  logic              step_set,
    input  logic              step_clr,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [FLAG_W-1:0] fl;
    } state_t;

    state_t st_d, st_q;

    alu_op_e           op;
    logic [DATA_W-1:0] alu_res;
    logic              cf, af, of, sf, zf, pf;
    logic [NUM_CTL-1:0] ctl_set, ctl_clr, ctl_next;

    assign op      = alu_op_e'(op_sel);
    assign ctl_set = {dir_set, int_set, step_set};
    assign ctl_clr = {dir_clr, int_clr, step_clr};

    alu_datapath #(.DATA_W(DATA_W)) i_datapath (
        .op       (op),
        .word_mode(word_mode),
        .a        (opa),
        .b        (opb),
        .carry_in (st_q.fl[FB_CARRY]),
        .res      (alu_res),
        .cf       (cf),
        .af       (af),
        .of       (of)
    );

    alu_status #(.DATA_W(DATA_W)) i_status (
        .word_mode(word_mode),
        .res      (alu_res),
        .sf       (sf),
        .zf       (zf),
        .pf       (pf)
    );

    // control flag bits: index 0 step, 1 interrupt, 2 direction
    for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
        always_comb begin
            if (ctl_clr[g]) begin
                ctl_next[g] = 1'b0;
            end else if (ctl_set[g]) begin
                ctl_next[g] = 1'b1;
            end else begin
                ctl_next[g] = st_q.fl[FB_STEP + g];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            st_d.fl[FB_CARRY] = cf;
            st_d.fl[FB_PAR]   = pf;
            st_d.fl[FB_HALF]  = af;
            st_d.fl[FB_ZERO]  = zf;
            st_d.fl[FB_SIGN]  = sf;
            st_d.fl[FB_OVF]   = of;
            if (op != OP_CMP) begin
                st_d.res = alu_res;
            end
        end
        st_d.fl[FB_DIR:FB_STEP] = ctl_next;
        st_d.fl[FLAG_W-1:12]    = '0;
        st_d.fl[5]              = 1'b0;
        st_d.fl[3]              = 1'b0;
        st_d.fl[FB_ONE]         = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.res <= '0;
            st_q.fl  <= FLAGS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.res;
    assign flags  = st_q.fl;

    p_logic_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel >= 3'd5)) |=> (!flags[FB_CARRY] && !flags[FB_OVF] && !flags[FB_HALF]));

    p_cmp_holds_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == 3'd4)) |=> $stable(result));

    p_byte_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !word_mode && (op_sel != 3'd4)) |=> (result[DATA_W-1:DATA_W/2] == '0));

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dir_clr |=> !flags[FB_DIR]);

    p_set_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_set && !dir_clr) |=> flags[FB_DIR]);

    p_fixed_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FB_ONE] && !flags[3] && !flags[5] && (flags[FLAG_W-1:12] == '0)));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(result) && $stable(flags[7:0]) && $stable(flags[FB_OVF])));

    p_zero_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && word_mode && (op_sel != 3'd4)) |=> (flags[FB_ZERO] == (result == '0)));

endmodule

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic        word_mode = 1'b0;
    logic [15:0] opa = 16'h0, opb = 16'h0;
    logic        dir_set = 0, dir_clr = 0, int_set = 0, int_clr = 0, step_set = 0, step_clr = 0;
    logic [15:0] result, flags;

    always #5 clk = ~clk;

    alu_flag_unit i_alu_flag_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .word_mode(word_mode), .opa(opa), .opb(opb),
        .dir_set(dir_set), .dir_clr(dir_clr), .int_set(int_set), .int_clr(int_clr),
        .step_set(step_set), .step_clr(step_clr),
        .result(result), .flags(flags)
    );

    typedef struct {
        logic [15:0] res;
        logic [15:0] fl;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          n_vec = 0;
    int          n_bad = 0;
    logic [15:0] m_res = 16'h0;
    logic [15:0] m_fl  = 16'h0002;
    int          cycles = 0;

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual cycles=%0d expected < 100000", cycles);
            finish_run();
        end
    end

    // independent model of the requirements
    task automatic model(input int op, input bit w, input int a, input int b);
        int mask, half, full, ua, ub, sa, sb, cin, r, wide, ss, ones;
        bit cf, af, of;
        mask = w ? 32'hFFFF : 32'hFF;
        half = w ? 32'h8000 : 32'h80;
        full = mask + 1;
        ua = a & mask; ub = b & mask;
        sa = (ua >= half) ? ua - full : ua;
        sb = (ub >= half) ? ub - full : ub;
        cin = (op == 1 || op == 3) ? int'(m_fl[0]) : 0;
        cf = 0; af = 0; of = 0;
        if (op <= 1) begin
            wide = ua + ub + cin;
            cf = wide > mask;
            af = ((ua & 15) + (ub & 15) + cin) > 15;
            ss = sa + sb + cin;
            of = (ss > half - 1) || (ss < -half);
            r = wide & mask;
        end else if (op <= 4) begin
            wide = ua - ub - cin;
            cf = wide < 0;
            af = ((ua & 15) - (ub & 15) - cin) < 0;
            ss = sa - sb - cin;
            of = (ss > half - 1) || (ss < -half);
            r = wide & mask;
        end else if (op == 5) r = ua & ub;
        else if (op == 6) r = ua | ub;
        else r = ua ^ ub;
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        m_fl[0]  = cf;
        m_fl[2]  = (ones % 2) == 0;
        m_fl[4]  = af;
        m_fl[6]  = (r == 0);
        m_fl[7]  = ((r & half) != 0);
        m_fl[11] = of;
        if (op != 4) m_res = r[15:0];
    endtask

    // ctl bits: [5] dir_set [4] dir_clr [3] int_set [2] int_clr [1] step_set [0] step_clr
    task automatic drive(input bit valid, input int op, input bit w, input int a, input int b,
                         input logic [5:0] ctl, input string tag);
        item_t it;
        @(negedge clk);
        op_valid = valid; op_sel = op[2:0]; word_mode = w;
        opa = a[15:0]; opb = b[15:0];
        {dir_set, dir_clr, int_set, int_clr, step_set, step_clr} = ctl;
        if (valid) model(op, w, a, b);
        if (ctl[4]) m_fl[10] = 0; else if (ctl[5]) m_fl[10] = 1;
        if (ctl[2]) m_fl[9] = 0;  else if (ctl[3]) m_fl[9] = 1;
        if (ctl[0]) m_fl[8] = 0;  else if (ctl[1]) m_fl[8] = 1;
        it.res = m_res; it.fl = m_fl; it.tag = tag;
        @(posedge clk);
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                n_vec++;
                if (result !== it.res || flags !== it.fl) begin
                    n_bad++;
                    $display("FAIL %s: actual res=%h flags=%h expected res=%h flags=%h",
                             it.tag, result, flags, it.res, it.fl);
                end
            end
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        n_vec++;
        if (result !== 16'h0 || flags !== 16'h0002) begin
            n_bad++;
            $display("FAIL R13 reset: actual res=%h flags=%h expected res=0000 flags=0002", result, flags);
        end
        @(negedge clk);
        rst_n = 1'b1;

        drive(1, 0, 1, 16'h1234, 16'h1111, 6'b0, "R1 word add");
        drive(1, 0, 1, 16'hFFFF, 16'h0001, 6'b0, "R1 R5 word carry zero");
        drive(1, 1, 1, 16'h0010, 16'h0020, 6'b0, "R1 adc with carry");
        drive(1, 0, 1, 16'h7FFF, 16'h0001, 6'b0, "R3 R4 word overflow");
        drive(1, 0, 0, 16'hAB7F, 16'h0001, 6'b0, "R3 R9 byte overflow");
        drive(1, 0, 0, 16'h00FF, 16'hFF01, 6'b0, "R1 R9 byte carry");
        drive(1, 1, 0, 16'h0000, 16'h0000, 6'b0, "R1 byte adc carry in");
        drive(1, 2, 1, 16'h0000, 16'h0001, 6'b0, "R2 R4 word borrow");
        drive(1, 3, 1, 16'h0005, 16'h0003, 6'b0, "R2 sbb borrow in");
        drive(1, 2, 1, 16'h8000, 16'h0001, 6'b0, "R3 word sub overflow");
        drive(1, 2, 0, 16'h0080, 16'h0001, 6'b0, "R3 byte sub overflow");
        drive(1, 2, 0, 16'h0010, 16'h0001, 6'b0, "R4 byte half borrow");
        drive(1, 0, 0, 16'h0008, 16'h0008, 6'b0, "R4 byte half carry");
        drive(1, 4, 1, 16'h0003, 16'h0007, 6'b0, "R8 compare");
        drive(1, 4, 1, 16'h4444, 16'h4444, 6'b0, "R8 compare equal");
        drive(1, 0, 1, 16'h7FFF, 16'h0001, 6'b0, "R3 set overflow");
        drive(1, 5, 1, 16'hF0F0, 16'hFF00, 6'b0, "R7 and clears");
        drive(1, 0, 1, 16'hFFFF, 16'hFFFF, 6'b0, "R1 set carry");
        drive(1, 6, 1, 16'h0F00, 16'h00F3, 6'b0, "R7 R6 or");
        drive(1, 7, 0, 16'h12FF, 16'h3400, 6'b0, "R7 R9 byte xor");
        drive(1, 7, 1, 16'h0101, 16'h0000, 6'b0, "R6 parity low byte only");
        drive(1, 7, 1, 16'h0300, 16'h0001, 6'b0, "R6 odd parity");
        drive(0, 0, 1, 16'hFFFF, 16'h0001, 6'b0, "R12 idle hold");
        drive(0, 0, 1, 16'h0000, 16'h0000, 6'b101010, "R10 set all ctl");
        drive(1, 0, 1, 16'h0001, 16'h0001, 6'b000000, "R10 ctl kept");
        drive(0, 0, 1, 16'h0000, 16'h0000, 6'b010100, "R10 clr dir int");
        drive(1, 2, 1, 16'h0000, 16'h0000, 6'b110111, "R10 clear wins");
        drive(0, 0, 1, 16'h0000, 16'h0000, 6'b001000, "R10 set int");
        drive(1, 0, 1, 16'hFFFF, 16'hFFFF, 6'b0, "R11 fixed bits");
        drive(1, 2, 0, 16'hFF00, 16'h0001, 6'b0, "R2 R5 byte sign");
        drive(0, 7, 0, 16'h0000, 16'h0000, 6'b0, "R12 idle");
        drive(0, 0, 0, 16'h0000, 16'h0000, 6'b0, "R12 idle");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule